// File: doc/BRIEF.md
# Dual-Bin Binary Arithmetic Encoder

This block is the interval-coding stage of an entropy encoder that handles two binary decisions per step. Upstream logic has already turned syntax into bins and already knows the context of each bin, so each step arrives with the bin values and a 6-bit probability code for each bin. In pair mode, the two bins are combined into one symbol from a four-letter alphabet. The current interval is split into four parts with three multiplications that run side by side. The part that matches the symbol becomes the new interval.

The engine holds a 14-bit range and a 14-bit low. After every accepted step, whether it carried one bin or two, it renormalizes once. Renormalization sends out settled bits and counts the bits it cannot settle yet. Those bits are resolved later, when a carry decision is known. Bits leave one per cycle on a valid/ready pair. Each step can choose single-bin or pair coding on its own. When a group coded in pairs has an odd number of bins, the last pair carries a padding bin with a fixed, strongly skewed probability. A flush request ends the stream: it writes out the full low value and then raises a sticky done.

Top module: `pair_arith_enc`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0. The interval starts with low = 0 and range = 2^14 − 1.
- R2: A probability code p (1..63) means the chance of a 0 bin is p/64. In single mode (in_pair = 0), define W0 = floor(range·p_a/64). A 0 bin keeps low and sets range = W0. A 1 bin adds W0 to low and sets range = range − W0.
- R3: In pair mode, W0 and W1 = range − W0 are each split by p_b. This gives W00 = floor(W0·p_b/64), W01 = W0 − W00, W10 = floor(W1·p_b/64) and W11 = W1 − W10. The symbols are ordered 00, 01, 10, 11, with bin_a as the upper digit. Low advances by the sum of the widths ordered before the chosen symbol, and range becomes the chosen width. That width is never zero.
- R4: In pair mode with in_pad = 1, the second bin is coded as value 1 with probability code 1, so Pr(0) = 1/64. in_bin_b and in_prob_b have no effect on the output bits.
- R5: After each step, the engine doubles range and low while range < 2^12. On each doubling, a low below 2^12 settles a 0. A low of 2^13 or more settles a 1, and 2^13 is subtracted first. Any other low defers one bit, and 2^12 is subtracted first. A step is accepted only when range ≥ 2^12.
- R6: Each settled bit b is sent out, followed at once by all bits deferred since the last settled bit, each as the complement of b.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_bit hold. in_ready is 0 while bits are pending or renormalization is running.
- R8: Single-bin and pair steps can be mixed in any order, and the choice applies to each step on its own.
- R9: A flush_req seen while in_ready is 1 and in_valid is 0 writes out the 14 bits of low, MSB first. The first of these bits carries any deferred bits. After that, done rises and stays 1, and in_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Step request |
| in_ready | output | 1 | Engine can accept a step or flush |
| in_pair | input | 1 | 1: code two bins, 0: code bin_a only |
| in_pad | input | 1 | Pair mode: replace the second bin with the padding bin |
| in_bin_a | input | 1 | First bin value |
| in_bin_b | input | 1 | Second bin value |
| in_prob_a | input | 6 | Probability code of first bin (Pr(0) = p/64) |
| in_prob_b | input | 6 | Probability code of second bin |
| flush_req | input | 1 | Terminate the stream |
| out_valid | output | 1 | out_bit holds a coded bit |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Consumer takes out_bit |
| done | output | 1 | Stream terminated (sticky) |

## Verification
A wrong width, a wrong offset or a wrong renormalization decision changes the coded bitstream. The first bit where it differs can appear after a delay: it shows up no later than the next settled bit, which can wait behind a run of deferred bits, or no later than the flush. The flush writes out the whole low register, so any difference in the final interval still reaches the ports. The bench therefore compares the complete stream, including the tail, against a bit-exact model. A broken deferral count shows up as a stream that is too long or too short. A broken handshake shows up as a dropped or repeated bit when the consumer stalls.

// File: rtl/enc2_pkg.sv
package enc2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_EMIT,
    ST_FLUSH,
    ST_DONE
  } enc_state_t;

  // outcome of one renormalization iteration
  typedef enum logic [1:0] {
    RN_DONE,
    RN_ZERO,
    RN_ONE,
    RN_DEFER
  } rn_kind_t;
endpackage

// File: rtl/enc2_split.sv
// Combinational interval subdivision: three parallel scalings.
module enc2_split #(
  parameter int RANGE_W = 14,
  parameter int PROB_W  = 6
) (
  input  logic [RANGE_W-1:0] range_i,
  input  logic [PROB_W-1:0]  prob_a_i,
  input  logic [PROB_W-1:0]  prob_b_i,
  input  logic               pair_i,
  input  logic               pad_i,
  input  logic               bin_a_i,
  input  logic               bin_b_i,
  output logic [RANGE_W-1:0] width_o,
  output logic [RANGE_W-1:0] offset_o
);
  localparam int PROD_W = RANGE_W + PROB_W;

  function automatic logic [RANGE_W-1:0] scale(input logic [RANGE_W-1:0] r,
                                               input logic [PROB_W-1:0]  p);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(r) * PROD_W'(p);
    return prod[PROD_W-1:PROB_W];
  endfunction

  logic [PROB_W-1:0]  pb_eff;
  logic               b_eff;
  logic [RANGE_W-1:0] w0, w1, w00, w01, w10, w11;

  always_comb begin
    pb_eff = pad_i ? PROB_W'(1) : prob_b_i;
    b_eff  = pad_i | bin_b_i;
    w0  = scale(range_i, prob_a_i);
    w1  = range_i - w0;
    w00 = scale(w0, pb_eff);
    w01 = w0 - w00;
    w10 = scale(w1, pb_eff);
    w11 = w1 - w10;
    if (!pair_i) begin
      width_o  = bin_a_i ? w1 : w0;
      offset_o = bin_a_i ? w0 : '0;
    end else begin
      case ({bin_a_i, b_eff})
        2'b00:   begin width_o = w00; offset_o = '0;        end
        2'b01:   begin width_o = w01; offset_o = w00;       end
        2'b10:   begin width_o = w10; offset_o = w0;        end
        default: begin width_o = w11; offset_o = w0 + w10;  end
      endcase
    end
  end
endmodule

// File: rtl/enc2_bitout.sv
// Sends one resolved bit followed by its deferred complements.
module enc2_bitout #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_bit_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] left_q;
  logic             bit_q, first_q;
  logic             take;

  assign out_valid_o = (left_q != '0);
  assign empty_o     = (left_q == '0);
  assign out_bit_o   = first_q ? bit_q : ~bit_q;
  assign take        = out_valid_o & out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      bit_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (load_i) begin
      left_q  <= load_cnt_i;
      bit_q   <= load_bit_i;
      first_q <= 1'b1;
    end else if (take) begin
      left_q  <= left_q - 1'b1;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pair_arith_enc.sv
module pair_arith_enc #(
  parameter int RANGE_W = 14,
  parameter int PROB_W  = 6,
  parameter int OUTS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_pair,
  input  logic              in_pad,
  input  logic              in_bin_a,
  input  logic              in_bin_b,
  input  logic [PROB_W-1:0] in_prob_a,
  input  logic [PROB_W-1:0] in_prob_b,
  input  logic              flush_req,
  output logic              out_valid,
  output logic              out_bit,
  input  logic              out_ready,
  output logic              done
);
  import enc2_pkg::*;

  localparam logic [RANGE_W-1:0] QTR  = RANGE_W'(1) << (RANGE_W - 2);
  localparam logic [RANGE_W-1:0] HALF = RANGE_W'(1) << (RANGE_W - 1);
  localparam int FCNT_W = $clog2(RANGE_W + 1);
  localparam int LCNT_W = OUTS_W + 1;

  enc_state_t         state_q;
  logic [RANGE_W-1:0] low_q, range_q;
  logic [OUTS_W-1:0]  outs_q;
  logic [FCNT_W-1:0]  flush_cnt_q;
  logic               ret_flush_q;

  // named internal events
  logic               step_fire, idle_w, flushing_w, emit_empty;
  logic [RANGE_W-1:0] sub_width, sub_off, low_adj;
  rn_kind_t           rn_kind;
  logic               load, load_bit;
  logic [LCNT_W-1:0]  load_cnt;

  function automatic rn_kind_t rn_classify(input logic [RANGE_W-1:0] r,
                                           input logic [RANGE_W-1:0] l);
    if (r >= QTR)       return RN_DONE;
    else if (l < QTR)   return RN_ZERO;
    else if (l >= HALF) return RN_ONE;
    else                return RN_DEFER;
  endfunction

  enc2_split #(.RANGE_W(RANGE_W), .PROB_W(PROB_W)) u_split (
    .range_i (range_q),
    .prob_a_i(in_prob_a),
    .prob_b_i(in_prob_b),
    .pair_i  (in_pair),
    .pad_i   (in_pad),
    .bin_a_i (in_bin_a),
    .bin_b_i (in_bin_b),
    .width_o (sub_width),
    .offset_o(sub_off)
  );

  assign idle_w     = (state_q == ST_IDLE);
  assign in_ready   = idle_w;
  assign step_fire  = in_valid & idle_w;
  assign done       = (state_q == ST_DONE);
  assign flushing_w = (state_q == ST_FLUSH) || (state_q == ST_DONE) ||
                      ((state_q == ST_EMIT) && ret_flush_q);
  assign rn_kind    = rn_classify(range_q, low_q);

  always_comb begin
    case (rn_kind)
      RN_ONE:   low_adj = low_q - HALF;
      RN_DEFER: low_adj = low_q - QTR;
      default:  low_adj = low_q;
    endcase
    load     = ((state_q == ST_NORM) && (rn_kind == RN_ZERO || rn_kind == RN_ONE)) ||
               ((state_q == ST_FLUSH) && (flush_cnt_q != '0));
    load_bit = (state_q == ST_FLUSH) ? low_q[RANGE_W-1] : (rn_kind == RN_ONE);
    load_cnt = LCNT_W'(outs_q) + LCNT_W'(1);
  end

  enc2_bitout #(.CNT_W(LCNT_W)) u_bitout (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_bit_i (load_bit),
    .load_cnt_i (load_cnt),
    .out_ready_i(out_ready),
    .out_valid_o(out_valid),
    .out_bit_o  (out_bit),
    .empty_o    (emit_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      low_q       <= '0;
      range_q     <= '1;
      outs_q      <= '0;
      flush_cnt_q <= '0;
      ret_flush_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            low_q   <= low_q + sub_off;
            range_q <= sub_width;
            state_q <= (sub_width < QTR) ? ST_NORM : ST_IDLE;
          end else if (flush_req) begin
            flush_cnt_q <= FCNT_W'(RANGE_W);
            state_q     <= ST_FLUSH;
          end
        end
        ST_NORM: begin
          if (rn_kind == RN_DONE) begin
            state_q <= ST_IDLE;
          end else begin
            range_q <= {range_q[RANGE_W-2:0], 1'b0};
            low_q   <= {low_adj[RANGE_W-2:0], 1'b0};
            if (rn_kind == RN_DEFER) begin
              outs_q <= outs_q + 1'b1;
            end else begin
              outs_q      <= '0;
              ret_flush_q <= 1'b0;
              state_q     <= ST_EMIT;
            end
          end
        end
        ST_EMIT: begin
          if (emit_empty) state_q <= ret_flush_q ? ST_FLUSH : ST_NORM;
        end
        ST_FLUSH: begin
          if (flush_cnt_q == '0) begin
            state_q <= ST_DONE;
          end else begin
            low_q       <= {low_q[RANGE_W-2:0], 1'b0};
            flush_cnt_q <= flush_cnt_q - 1'b1;
            outs_q      <= '0;
            ret_flush_q <= 1'b1;
            state_q     <= ST_EMIT;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/enc2_chk.sv
module enc2_chk #(
  parameter int RANGE_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_fire,
  input logic [RANGE_W-1:0] sub_width,
  input logic               idle_w,
  input logic               flushing_w,
  input logic [RANGE_W-1:0] low_q,
  input logic [RANGE_W-1:0] range_q,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_bit,
  input logic               out_ready,
  input logic               done
);
  localparam logic [RANGE_W:0] FULL = {1'b1, {RANGE_W{1'b0}}};
  localparam logic [RANGE_W-1:0] QTR = RANGE_W'(1) << (RANGE_W - 2);

  a_r3_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (sub_width != '0));

  a_r5_range_floor: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (range_q >= QTR));

  a_r5_interval_inside: assert property (@(posedge clk) disable iff (!rst_n)
    !flushing_w |-> (({1'b0, low_q} + {1'b0, range_q}) <= FULL));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  a_r7_no_accept_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid));
endmodule

bind pair_arith_enc enc2_chk #(.RANGE_W(RANGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_fire (step_fire),
  .sub_width (sub_width),
  .idle_w    (idle_w),
  .flushing_w(flushing_w),
  .low_q     (low_q),
  .range_q   (range_q),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .out_ready (out_ready),
  .done      (done)
);

// File: tb/sim_pair_arith_enc.sv
module sim_pair_arith_enc;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 14;
  localparam int PW = 6;
  localparam int WATCHDOG = 150000;
  localparam int unsigned QTR  = 1 << (RW - 2);
  localparam int unsigned HALF = 1 << (RW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_pair = 1'b0, in_pad = 1'b0, in_bin_a = 1'b0, in_bin_b = 1'b0;
  logic [PW-1:0] in_prob_a = '0, in_prob_b = '0;
  logic flush_req = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, done;

  pair_arith_enc #(.RANGE_W(RW), .PROB_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pair(in_pair), .in_pad(in_pad), .in_bin_a(in_bin_a), .in_bin_b(in_bin_b),
    .in_prob_a(in_prob_a), .in_prob_b(in_prob_b), .flush_req(flush_req),
    .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int unsigned m_low, m_range, m_outs;
  bit exp_q[$];
  bit got_q[$];
  bit run_a[$];
  bit rand_ready = 1'b0;
  bit prev_stall = 1'b0, prev_bit = 1'b0;
  int stall_err = 0;

  // consumer: decide ready for the coming edge and record the transfer
  always @(negedge clk) begin
    bit r;
    if (prev_stall && (!out_valid || out_bit != prev_bit)) stall_err++;
    r = rand_ready ? ($urandom_range(0, 1) == 1) : 1'b1;
    out_ready = r;
    if (out_valid && r) got_q.push_back(out_bit);
    prev_stall = out_valid && !r;
    prev_bit   = out_bit;
  end

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic void m_put(bit b);
    exp_q.push_back(b);
    repeat (m_outs) exp_q.push_back(!b);
    m_outs = 0;
  endfunction

  function automatic void m_step(bit pair, bit pad, bit a, bit b, int unsigned pa, int unsigned pb);
    int unsigned w0, w1, w00, w10, w, off;
    w0 = (m_range * pa) >> PW;
    w1 = m_range - w0;
    if (!pair) begin
      off = a ? w0 : 0;
      w   = a ? w1 : w0;
    end else begin
      if (pad) begin b = 1'b1; pb = 1; end
      w00 = (w0 * pb) >> PW;
      w10 = (w1 * pb) >> PW;
      case ({a, b})
        2'b00:   begin off = 0;        w = w00;      end
        2'b01:   begin off = w00;      w = w0 - w00; end
        2'b10:   begin off = w0;       w = w10;      end
        default: begin off = w0 + w10; w = w1 - w10; end
      endcase
    end
    m_low   = m_low + off;
    m_range = w;
    while (m_range < QTR) begin
      if (m_low < QTR) m_put(1'b0);
      else if (m_low >= HALF) begin m_low = m_low - HALF; m_put(1'b1); end
      else begin m_low = m_low - QTR; m_outs++; end
      m_range = m_range * 2;
      m_low   = m_low * 2;
    end
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; flush_req = 1'b0; rand_ready = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete(); got_q.delete();
    m_low = 0; m_range = (1 << RW) - 1; m_outs = 0;
    stall_err = 0; prev_stall = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic drive_step(bit pair, bit pad, bit a, bit b, int unsigned pa, int unsigned pb);
    m_step(pair, pad, a, b, pa, pb);
    @(negedge clk);
    in_valid = 1'b1; in_pair = pair; in_pad = pad; in_bin_a = a; in_bin_b = b;
    in_prob_a = PW'(pa); in_prob_b = PW'(pb);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    for (int i = RW - 1; i >= 0; i--) m_put(bit'((m_low >> i) & 1));
    @(negedge clk);
    flush_req = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    flush_req = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_stream(string tag);
    int bad;
    bad = -1;
    chk(got_q.size() == exp_q.size(), tag, "stream length", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    chk(bad < 0, tag, "first mismatching bit index (-1 = none)", bad, -1);
  endtask

  task automatic pad_run(bit junk_b, int unsigned junk_p);
    drive_step(1, 0, 1, 0, 30, 40);
    drive_step(1, 1, 0, junk_b, 12, junk_p);
    drive_step(0, 0, 1, 0, 50, 3);
    drive_step(1, 1, 1, junk_b, 60, junk_p);
    drive_step(1, 1, 0, !junk_b, 2, junk_p);
    do_flush();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog (all R): got timeout after %0d cycles expected done", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1: reset state, then R9: flush of the fresh interval -> 14 zeros
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    do_flush();
    cmp_stream("R9");
    chk(done == 1'b1, "R9", "done after flush", done, 1);
    chk(in_ready == 1'b0, "R9", "in_ready after flush", in_ready, 0);
    repeat (5) @(negedge clk);
    chk(done == 1'b1 && got_q.size() == RW, "R9", "done sticky / no extra bits", got_q.size(), RW);

    // R2: directed single-bin steps
    do_reset();
    drive_step(0, 0, 0, 0, 32, 0); drive_step(0, 0, 1, 0, 32, 0);
    drive_step(0, 0, 1, 0, 1, 0);  drive_step(0, 0, 0, 0, 63, 0);
    drive_step(0, 0, 1, 0, 63, 0); drive_step(0, 0, 0, 0, 1, 0);
    drive_step(0, 0, 1, 0, 17, 0); drive_step(0, 0, 0, 0, 40, 0);
    do_flush();
    cmp_stream("R2");

    // R3: all four pair symbols, mixed probabilities
    do_reset();
    drive_step(1, 0, 0, 0, 20, 50); drive_step(1, 0, 0, 1, 20, 50);
    drive_step(1, 0, 1, 0, 20, 50); drive_step(1, 0, 1, 1, 20, 50);
    drive_step(1, 0, 1, 1, 63, 63); drive_step(1, 0, 0, 0, 1, 1);
    drive_step(1, 0, 1, 0, 33, 7);  drive_step(1, 0, 0, 1, 5, 60);
    do_flush();
    cmp_stream("R3");

    // R4: padding bin ignores in_bin_b / in_prob_b
    do_reset();
    pad_run(1'b0, 5);
    cmp_stream("R4");
    run_a = got_q;
    do_reset();
    pad_run(1'b1, 63);
    cmp_stream("R4");
    begin
      int diff;
      diff = -1;
      for (int i = 0; i < run_a.size() && i < got_q.size(); i++)
        if (diff < 0 && run_a[i] != got_q[i]) diff = i;
      chk(run_a.size() == got_q.size() && diff < 0, "R4", "pad runs differ at bit", diff, -1);
    end

    // R5 R6: extreme widths (12-shift renormalization) and deferral runs, stalled consumer
    do_reset();
    rand_ready = 1'b1;
    for (int i = 0; i < 10; i++) drive_step(1, 0, 0, 0, 1, 1);
    for (int i = 0; i < 10; i++) drive_step(1, 0, 1, 1, 63, 63);
    for (int i = 0; i < 10; i++) drive_step(0, 0, i % 2, 0, 32, 0);
    for (int i = 0; i < 6; i++)  drive_step(1, 0, 1, 0, 1, 63);
    do_flush();
    cmp_stream("R5 R6");

    // R8 R6 R7: random mix of modes under random back-pressure
    do_reset();
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      bit pr, pd;
      pr = ($urandom_range(0, 1) == 1);
      pd = pr && ($urandom_range(0, 3) == 0);
      drive_step(pr, pd, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 $urandom_range(1, 63), $urandom_range(1, 63));
    end
    do_flush();
    cmp_stream("R8 R6");
    chk(stall_err == 0, "R7", "changes of out_bit/out_valid during stall", stall_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule